// File: doc/BRIEF.md
# Streaming Luma Sobel Edge Filter

This block sits in a camera pixel pipeline and turns a stream of 24-bit colour pixels into a stream of 8-bit edge strengths. Each accepted pixel is first reduced to an 8-bit intensity with fixed weighted coefficients. The intensity is pushed into a 3x3 window built from two line stores and three column registers. A horizontal and a vertical 3x3 Sobel kernel are applied to that window. The output is the sum of the two absolute gradients, clipped to the pixel range, and it can optionally be turned into a binary edge map with a programmable threshold.

Input and output are valid-qualified pixel streams that carry a start-of-frame and an end-of-line flag. Every accepted input pixel produces exactly one output pixel a fixed number of clocks later, with its flags carried through unchanged. The window is aligned to the newest pixel: the output slot of pixel (row r, column c) holds the gradient of the 3x3 neighbourhood spanning rows r-2..r and columns c-2..c, which is centred on (r-1, c-1). The line stores hold one line of up to `LINE_W` pixels (720 by default, enough for a 720x480 frame at 60 frames per second on a pixel clock of 62.5 MHz or more). A small write port loads the threshold value and its enable.

Top module: `edge_sobel_stream`

## Requirements
- R1: Intensity is (77·R + 150·G + 29·B + 128) >> 8, with R in in_rgb[23:16], G in in_rgb[15:8] and B in in_rgb[7:0].
- R2: Let L be the intensity and let the window span rows r-2..r and columns c-2..c. The output for pixel (r, c) uses Gx = (L[r-2][c] + 2·L[r-1][c] + L[r][c]) − (L[r-2][c-2] + 2·L[r-1][c-2] + L[r][c-2]) and Gy = (L[r][c-2] + 2·L[r][c-1] + L[r][c]) − (L[r-2][c-2] + 2·L[r-2][c-1] + L[r-2][c]).
- R3: The magnitude is |Gx| + |Gy|, saturated to 255.
- R4: A pixel whose row is 0 or 1, or whose column is 0 or 1, outputs 0. This holds whether or not the threshold is enabled.
- R5: A pixel flagged start-of-frame is row 0, column 0, even in the middle of a frame.
- R6: A pixel flagged end-of-line ends its row, and the next pixel is column 0 of the following row. Lines shorter than LINE_W are handled correctly.
- R7: Cycles with in_valid low change neither the window nor the row or column position, so gaps in the stream do not alter any result.
- R8: A cycle with cfg_wr high loads cfg_thr_en and cfg_thr; both reset to 0. With the enable set, the output is 255 when the magnitude is at or above the threshold and 0 otherwise.
- R9: Each accepted pixel yields one output with out_valid high, in order, with its own start-of-frame and end-of-line flags. A pixel sampled at clock edge k appears after edge k+2+MAG_PIPE.
- R10: During and right after reset, out_valid, out_sof, out_eol and out_mag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present this cycle |
| in_sof | input | 1 | Input pixel is first of a frame |
| in_eol | input | 1 | Input pixel is last of its line |
| in_rgb | input | 3*CH_W | Colour pixel, red in the top byte |
| cfg_wr | input | 1 | Load threshold settings |
| cfg_thr_en | input | 1 | Threshold enable value to load |
| cfg_thr | input | CH_W | Threshold value to load |
| out_valid | output | 1 | Output pixel present this cycle |
| out_sof | output | 1 | Output pixel is first of a frame |
| out_eol | output | 1 | Output pixel is last of its line |
| out_mag | output | CH_W | Edge magnitude or binary edge value |

## Verification
The bench builds the filter with LINE_W = 8 and MAG_PIPE = 1. Short lines let a handful of pixels reach the interior of the window, the rotation of the line stores at each line end, and the column clamp. The extra magnitude stage is also switched on, so the longer latency is what gets measured. Frames are a few rows tall and use flat, stepped, checkered, single-channel ramp and pseudo-random images. These include short lines, idle gaps and a start-of-frame in the middle of a frame. The threshold is tried at 0, at a mid value and at exactly the saturated magnitude.

// File: rtl/sobel_pkg.sv
package sobel_pkg;
   // Per-pixel stream qualifiers that travel alongside the data path.
   typedef struct packed {
      logic vld;
      logic sof;
      logic eol;
   } strm_tag_t;

   localparam int TAG_W = 3;
endpackage

// File: rtl/sobel_luma.sv
module sobel_luma
   import sobel_pkg::*;
#(
   parameter int CH_W = 8,
   parameter int FRAC = 8,
   parameter int K_R  = 77,
   parameter int K_G  = 150,
   parameter int K_B  = 29
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3*CH_W-1:0] rgb_i,
   input  strm_tag_t         tag_i,
   output logic [CH_W-1:0]   luma_o,
   output strm_tag_t         tag_o
);
   localparam int ACC_W = CH_W + FRAC + 1;

   if (K_R + K_G + K_B != (1 << FRAC)) begin : g_bad_weights
      $error("luma weights must sum to 2**FRAC");
   end
   if (FRAC < 1) begin : g_bad_frac
      $error("FRAC must be at least 1");
   end

   logic [ACC_W-1:0] acc;
   logic [CH_W-1:0]  luma_next;

   always_comb begin
      acc = ACC_W'(K_R) * ACC_W'(rgb_i[3*CH_W-1 -: CH_W])
          + ACC_W'(K_G) * ACC_W'(rgb_i[2*CH_W-1 -: CH_W])
          + ACC_W'(K_B) * ACC_W'(rgb_i[CH_W-1:0])
          + ACC_W'(1 << (FRAC - 1));
      luma_next = CH_W'(acc >> FRAC);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         luma_o <= '0;
         tag_o  <= '0;
      end else begin
         tag_o <= tag_i;
         if (tag_i.vld) luma_o <= luma_next;
      end
   end
endmodule

// File: rtl/sobel_window.sv
module sobel_window #(
   parameter int CH_W   = 8,
   parameter int LINE_W = 720
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        vld_i,
   input  logic                        sof_i,
   input  logic                        eol_i,
   input  logic [CH_W-1:0]             luma_i,
   output logic [2:0][2:0][CH_W-1:0]   win_o,
   output logic                        edge_o
);
   localparam int COL_W = $clog2(LINE_W);

   if (LINE_W < 3) begin : g_bad_line
      $error("LINE_W must be at least 3");
   end

   logic [COL_W-1:0] col_q, col_cur;
   logic [1:0]       row_q, row_cur;
   logic             bank_q;
   logic [CH_W-1:0]  store [2][LINE_W];
   logic [CH_W-1:0]  rd_prev, rd_old;
   logic [2:0][CH_W-1:0] tap;

   // Position of the pixel being accepted; start-of-frame forces the origin.
   always_comb begin
      col_cur = sof_i ? '0 : col_q;
      row_cur = sof_i ? '0 : row_q;
      rd_prev = store[bank_q][col_cur];
      rd_old  = store[~bank_q][col_cur];
      tap[0]  = rd_old;
      tap[1]  = rd_prev;
      tap[2]  = luma_i;
   end

   // The bank holding the older line is overwritten with the new line.
   always_ff @(posedge clk) begin
      if (vld_i) store[~bank_q][col_cur] <= luma_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_q  <= '0;
         row_q  <= '0;
         bank_q <= 1'b0;
      end else if (vld_i) begin
         if (eol_i) begin
            col_q  <= '0;
            row_q  <= (row_cur == 2'd2) ? 2'd2 : row_cur + 2'd1;
            bank_q <= ~bank_q;
         end else begin
            col_q  <= (col_cur == COL_W'(LINE_W - 1)) ? col_cur : col_cur + 1'b1;
            row_q  <= row_cur;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_o  <= '0;
         edge_o <= 1'b1;
      end else if (vld_i) begin
         for (int r = 0; r < 3; r++) begin
            win_o[r] <= {tap[r], win_o[r][2:1]};
         end
         edge_o <= (row_cur < 2'd2) || (col_cur < COL_W'(2));
      end
   end

   a_r7_hold_position: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_i |=> ($stable(col_q) && $stable(row_q) && $stable(bank_q) && $stable(win_o)));

   a_r6_column_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      col_q <= COL_W'(LINE_W - 1));

   a_r5_sof_origin: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && sof_i) |=> edge_o);
endmodule

// File: rtl/sobel_grad.sv
module sobel_grad #(
   parameter int CH_W     = 8,
   parameter bit MAG_PIPE = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [2:0][2:0][CH_W-1:0] win_i,
   input  logic                      edge_i,
   input  logic                      thr_en_i,
   input  logic [CH_W-1:0]           thr_i,
   output logic [CH_W-1:0]           mag_o
);
   localparam int TRI_W = CH_W + 2;
   localparam int SUM_W = TRI_W + 1;

   if (CH_W < 2) begin : g_bad_width
      $error("CH_W must be at least 2");
   end

   function automatic logic [TRI_W-1:0] tri3(input logic [CH_W-1:0] a,
                                             input logic [CH_W-1:0] b,
                                             input logic [CH_W-1:0] c);
      return TRI_W'(a) + (TRI_W'(b) << 1) + TRI_W'(c);
   endfunction

   function automatic logic [TRI_W-1:0] absdiff(input logic [TRI_W-1:0] p,
                                                input logic [TRI_W-1:0] q);
      return (p >= q) ? (p - q) : (q - p);
   endfunction

   logic [TRI_W-1:0] ax, ay, ax_s, ay_s;
   logic             edge_s;
   logic [SUM_W-1:0] sum;
   logic [CH_W-1:0]  sat, shaped, mag_next;

   always_comb begin
      ax = absdiff(tri3(win_i[0][2], win_i[1][2], win_i[2][2]),
                   tri3(win_i[0][0], win_i[1][0], win_i[2][0]));
      ay = absdiff(tri3(win_i[2][0], win_i[2][1], win_i[2][2]),
                   tri3(win_i[0][0], win_i[0][1], win_i[0][2]));
   end

   if (MAG_PIPE) begin : g_split
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ax_s   <= '0;
            ay_s   <= '0;
            edge_s <= 1'b1;
         end else begin
            ax_s   <= ax;
            ay_s   <= ay;
            edge_s <= edge_i;
         end
      end
   end else begin : g_merged
      assign ax_s   = ax;
      assign ay_s   = ay;
      assign edge_s = edge_i;
   end

   always_comb begin
      sum      = SUM_W'(ax_s) + SUM_W'(ay_s);
      sat      = (sum > SUM_W'({CH_W{1'b1}})) ? '1 : sum[CH_W-1:0];
      shaped   = thr_en_i ? ((sat >= thr_i) ? '1 : '0) : sat;
      mag_next = edge_s ? '0 : shaped;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) mag_o <= '0;
      else        mag_o <= mag_next;
   end
endmodule

// File: rtl/sobel_sync_delay.sv
module sobel_sync_delay #(
   parameter int W     = 3,
   parameter int DEPTH = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (DEPTH < 1) begin : g_bad_depth
      $error("DEPTH must be at least 1");
   end

   logic [DEPTH-1:0][W-1:0] stage;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage <= '0;
      end else begin
         stage[0] <= d_i;
         for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
      end
   end

   assign q_o = stage[DEPTH-1];
endmodule

// File: rtl/edge_sobel_stream.sv
module edge_sobel_stream
   import sobel_pkg::*;
#(
   parameter int CH_W     = 8,
   parameter int LINE_W   = 720,
   parameter int FRAC     = 8,
   parameter int K_R      = 77,
   parameter int K_G      = 150,
   parameter int K_B      = 29,
   parameter bit MAG_PIPE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic              in_eol,
   input  logic [3*CH_W-1:0] in_rgb,
   input  logic              cfg_wr,
   input  logic              cfg_thr_en,
   input  logic [CH_W-1:0]   cfg_thr,
   output logic              out_valid,
   output logic              out_sof,
   output logic              out_eol,
   output logic [CH_W-1:0]   out_mag
);
   localparam int LAT      = 3 + int'(MAG_PIPE);
   localparam int SYNC_DEP = LAT - 1;

   strm_tag_t             tag_in, tag_a, tag_out;
   logic [CH_W-1:0]       luma_a;
   logic [2:0][2:0][CH_W-1:0] win;
   logic                  edge_b;
   logic                  thr_en_q;
   logic [CH_W-1:0]       thr_q;

   assign tag_in.vld = in_valid;
   assign tag_in.sof = in_valid & in_sof;
   assign tag_in.eol = in_valid & in_eol;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr_en_q <= 1'b0;
         thr_q    <= '0;
      end else if (cfg_wr) begin
         thr_en_q <= cfg_thr_en;
         thr_q    <= cfg_thr;
      end
   end

   sobel_luma #(
      .CH_W(CH_W), .FRAC(FRAC), .K_R(K_R), .K_G(K_G), .K_B(K_B)
   ) u_luma (
      .clk(clk), .rst_n(rst_n), .rgb_i(in_rgb), .tag_i(tag_in),
      .luma_o(luma_a), .tag_o(tag_a)
   );

   sobel_window #(
      .CH_W(CH_W), .LINE_W(LINE_W)
   ) u_window (
      .clk(clk), .rst_n(rst_n), .vld_i(tag_a.vld), .sof_i(tag_a.sof),
      .eol_i(tag_a.eol), .luma_i(luma_a), .win_o(win), .edge_o(edge_b)
   );

   sobel_grad #(
      .CH_W(CH_W), .MAG_PIPE(MAG_PIPE)
   ) u_grad (
      .clk(clk), .rst_n(rst_n), .win_i(win), .edge_i(edge_b),
      .thr_en_i(thr_en_q), .thr_i(thr_q), .mag_o(out_mag)
   );

   sobel_sync_delay #(
      .W(TAG_W), .DEPTH(SYNC_DEP)
   ) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(tag_a), .q_o(tag_out)
   );

   assign out_valid = tag_out.vld;
   assign out_sof   = tag_out.sof;
   assign out_eol   = tag_out.eol;

   // Cycles since reset release, so the latency check never looks before reset.
   logic [2:0] since_rst;
   always_ff @(posedge clk) begin
      if (!rst_n)                      since_rst <= '0;
      else if (since_rst != 3'd7)      since_rst <= since_rst + 3'd1;
   end

   a_r9_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst > 3'(LAT)) |-> (out_valid == $past(in_valid, LAT)));

   a_r9_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (out_sof || out_eol) |-> out_valid);

   a_r4_frame_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_sof) |-> (out_mag == '0));

   a_r8_binary_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(thr_en_q)) |-> ((out_mag == '0) || (out_mag == '1)));
endmodule

// File: tb/test_edge_sobel_stream.sv
module test_edge_sobel_stream;
   localparam int CW  = 8;
   localparam int LW  = 8;
   localparam bit MP  = 1'b1;
   localparam int LAT = 3 + int'(MP);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
   logic [3*CW-1:0] in_rgb = '0;
   logic cfg_wr = 1'b0, cfg_thr_en = 1'b0;
   logic [CW-1:0] cfg_thr = '0;
   logic out_valid, out_sof, out_eol;
   logic [CW-1:0] out_mag;

   always #10 clk = ~clk;

   edge_sobel_stream #(.CH_W(CW), .LINE_W(LW), .MAG_PIPE(MP)) i_edge_sobel_stream (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eol(in_eol),
      .in_rgb(in_rgb), .cfg_wr(cfg_wr), .cfg_thr_en(cfg_thr_en), .cfg_thr(cfg_thr),
      .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol), .out_mag(out_mag)
   );

   int total = 0;
   int bad = 0;
   logic [9:0] exp_q[$];
   string tag_q[$];
   logic [9:0] mon_e;
   string mon_t;
   int m_row = 0, m_col = 0;
   int lum [8][LW];
   bit m_en = 1'b0;
   int m_thr = 0;

   task automatic chk(bit ok, string tag, int act, int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // R1: weighted intensity with rounding
   function automatic int luma_of(logic [23:0] p);
      return (77 * int'(p[23:16]) + 150 * int'(p[15:8]) + 29 * int'(p[7:0]) + 128) >> 8;
   endfunction

   // R2 / R3 / R8 reference for an interior slot
   function automatic int model_mag(int r, int c);
      int gx, gy, s;
      gx = (lum[r-2][c] + 2*lum[r-1][c] + lum[r][c])
         - (lum[r-2][c-2] + 2*lum[r-1][c-2] + lum[r][c-2]);
      gy = (lum[r][c-2] + 2*lum[r][c-1] + lum[r][c])
         - (lum[r-2][c-2] + 2*lum[r-2][c-1] + lum[r-2][c]);
      if (gx < 0) gx = -gx;
      if (gy < 0) gy = -gy;
      s = gx + gy;
      if (s > 255) s = 255;
      if (m_en) s = (s >= m_thr) ? 255 : 0;
      return s;
   endfunction

   function automatic logic [23:0] pix(int mode, int r, int c, int cols);
      logic [7:0] a, b, d;
      case (mode)
         0: return 24'h646464;
         1: return (c < cols/2) ? 24'h000000 : 24'hFFFFFF;
         2: return (r < 3) ? 24'h202020 : 24'hC8C8C8;
         3: begin
            a = 8'((r*53 + c*29 + 7) & 255);
            b = 8'((r*17 + c*71 + 90) & 255);
            d = 8'((r*91 + c*13 + 200) & 255);
            return {a, b, d};
         end
         4: return ((r + c) % 2 == 1) ? 24'hFFFFFF : 24'h000000;
         5: return {8'((c*36 + r*10) & 255), 16'h0000};
         default: return {16'h0000, 8'((c*33 + r*20) & 255)};
      endcase
   endfunction

   task automatic put_px(logic [23:0] rgb, bit sof, bit eol, string tag);
      int r, c, e;
      if (sof) begin m_row = 0; m_col = 0; end
      r = m_row; c = m_col;
      lum[r][c] = luma_of(rgb);
      e = (r < 2 || c < 2) ? 0 : model_mag(r, c);   // R4 border slots
      exp_q.push_back({sof, eol, e[7:0]});
      tag_q.push_back(tag);
      in_valid = 1'b1; in_sof = sof; in_eol = eol; in_rgb = rgb;
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eol = 1'b0;
      if (eol) begin m_row++; m_col = 0; end
      else m_col++;
   endtask

   task automatic frame(int rows, int cols, int mode, int gap, int limit, string tag);
      int n;
      n = 0;
      for (int r = 0; r < rows; r++) begin
         for (int c = 0; c < cols; c++) begin
            if (limit < 0 || n < limit) begin
               put_px(pix(mode, r, c, cols), (r == 0 && c == 0), (c == cols - 1), tag);
               for (int g = 0; g < gap; g++) @(negedge clk);
            end
            n++;
         end
      end
   endtask

   task automatic drain();
      repeat (LAT + 3) @(negedge clk);
   endtask

   task automatic set_cfg(bit en, int thr);
      cfg_wr = 1'b1; cfg_thr_en = en; cfg_thr = 8'(thr);
      @(negedge clk);
      cfg_wr = 1'b0;
      m_en = en; m_thr = thr;
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         total++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R9 unexpected output actual=%0d expected=none", out_mag);
         end else begin
            mon_e = exp_q.pop_front();
            mon_t = tag_q.pop_front();
            if ({out_sof, out_eol, out_mag} !== mon_e) begin
               bad++;
               $display("FAIL %s actual sof=%b eol=%b mag=%0d expected sof=%b eol=%b mag=%0d",
                        mon_t, out_sof, out_eol, out_mag, mon_e[9], mon_e[8], mon_e[7:0]);
            end
         end
      end
   end

   initial begin
      repeat (2000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int k;
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R10 valid in reset", int'(out_valid), 0);
      chk(out_mag == '0, "R10 mag in reset", int'(out_mag), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0 && out_sof == 1'b0 && out_eol == 1'b0,
          "R10 flags after reset", int'({out_sof, out_eol, out_valid}), 0);
      chk(out_mag == '0, "R10 mag after reset", int'(out_mag), 0);

      // R9 latency of a lone pixel
      put_px(24'h808080, 1'b1, 1'b1, "R9 lone pixel");
      k = 1;
      while (!out_valid && k < 20) begin @(negedge clk); k++; end
      chk(k == LAT, "R9 latency", k, LAT);
      drain();

      frame(5, 8, 0, 0, -1, "R2 flat");
      frame(5, 8, 1, 0, -1, "R2 vertical step");
      frame(6, 8, 2, 0, -1, "R2 horizontal step");
      frame(5, 8, 4, 0, -1, "R3 checker saturation");
      frame(6, 8, 3, 0, -1, "R3 mixed colour");
      frame(5, 8, 5, 0, -1, "R1 red ramp");
      frame(5, 8, 6, 0, -1, "R1 blue ramp");
      frame(5, 5, 3, 0, -1, "R6 short lines");
      frame(4, 8, 3, 0, -1, "R6 full lines");
      frame(5, 8, 3, 2, -1, "R7 gap two");
      frame(4, 6, 6, 1, -1, "R7 gap one");
      frame(3, 8, 3, 0, 19, "R5 cut frame");
      frame(5, 7, 3, 0, -1, "R5 restart frame");
      drain();

      set_cfg(1'b1, 60);
      frame(5, 8, 3, 0, -1, "R8 threshold mid");
      drain();
      set_cfg(1'b1, 255);
      frame(5, 8, 1, 0, -1, "R8 threshold equal");
      drain();
      set_cfg(1'b1, 0);
      frame(4, 8, 0, 0, -1, "R4 border under threshold");
      drain();
      set_cfg(1'b0, 0);
      frame(5, 8, 3, 1, -1, "R8 threshold off");
      drain();

      chk(exp_q.size() == 0, "R9 all outputs delivered", exp_q.size(), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule